// File: doc/BRIEF.md
# Windowed Pulse-Density Counter Decoder

This block turns a return-to-zero pulse-density bit stream into a binary number. It counts over a measurement window of a fixed number of converter clock slots. A reference counter advances once per slot, marked by a one-cycle `slotEn` strobe. A data counter of the same width advances once for each slot that carried a pulse on the stream. When the reference counter passes its all-ones value, its carry closes the window. On that same slot edge the data counter is frozen and its final value is captured into the result register.

Because the two counters have the same width `N`, the window length is `2**N` slots and the resolution is `N` bits. A stream that pulses in every slot saturates at the all-ones code and does not wrap. The host pulses `clear` to start a measurement. It then waits for `resultValid` and reads `result`, which holds until the next completed window. Between windows the block ignores both the stream and the slot strobe.

Top module: `pulse_window_decoder`

## Requirements
- R1: While `rstN` is low, and after it is released, `result` is zero and `resultValid` is low until a window completes.
- R2: A `clear` pulse zeroes both counters and opens a window. The window closes on exactly the `2**N`-th cycle in which `slotEn` is high, counted from that clear, however many idle cycles separate the slots.
- R3: A rising edge of `dataIn` is a pulse. This includes an edge in the same cycle as `slotEn`. The data count goes up by one for each slot that had at least one pulse since the previous slot. A level held high across several slots counts once.
- R4: On the clock edge that takes the final slot, `result` is loaded with the data count, including that final slot. `resultValid` is high for exactly one cycle after that edge.
- R5: The data count saturates at `2**N-1`. A window with a pulse in all `2**N` slots reports all ones.
- R6: After a window closes, slot strobes and pulses change neither `result` nor `resultValid` until the next `clear`.
- R7: A `clear` during a window discards it and starts a new one. A `clear` in the same cycle as the final slot wins: no `resultValid`, and `result` is unchanged.
- R8: `result` changes only in the cycle in which `resultValid` rises.
- R9: A `slotEn` strobe in the same cycle as `clear` is not counted as a slot of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zeroes the counters and starts a window |
| slotEn | input | 1 | One-cycle strobe per converter clock slot |
| dataIn | input | 1 | Pulse-density stream, synchronous to clk |
| result | output | N | Data count captured at the end of the last window |
| resultValid | output | 1 | One-cycle strobe when `result` is loaded |

## Verification
Two events can land in the same cycle: a `clear` and the window-closing slot strobe. The bench drives both on one edge after seven counted slots. It then judges that no valid strobe appears, that the old result stays in place, and that the colliding strobe is not taken as slot one of the new window: the valid strobe must follow the eighth later slot and not the seventh. The second overlap is a final-slot pulse meeting a data counter that is already at all ones. The full sweep of slot patterns provokes it with the all-pulse pattern, where the expected code is the clipped population count.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic [0:0] {
    PWD_IDLE = 1'b0,
    PWD_RUN  = 1'b1
  } pwdState_t;

  typedef struct packed {
    logic clearAll;  // zero both counters and the pulse catcher
    logic countEn;   // a slot is taken in the open window
    logic latch;     // final slot: capture result and strobe valid
  } pwdStrobes_t;

endpackage

// File: rtl/pwd_counter.sv
module pwd_counter #(
  parameter int W        = 8,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] stepped;
  logic [W-1:0] cntNext;

  generate
    if (SATURATE) begin : g_sat
      always_comb stepped = (cnt == TOP) ? cnt : cnt + ONE;
    end else begin : g_wrap
      always_comb stepped = cnt + ONE;
    end
  endgenerate

  always_comb begin
    if (clr)      cntNext = ZERO;
    else if (inc) cntNext = stepped;
    else          cntNext = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= ZERO;
    else       cnt <= cntNext;
  end

endmodule

// File: rtl/pwd_edge_catch.sv
module pwd_edge_catch (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  input  logic clr,
  input  logic consume,
  output logic hit
);

  logic prevData;
  logic pending;
  logic rise;

  assign rise = dataIn & ~prevData;
  assign hit  = pending | rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevData <= 1'b0;
      pending  <= 1'b0;
    end else begin
      prevData <= dataIn;
      if (clr || consume) pending <= 1'b0;
      else if (rise)      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/pwd_control.sv
module pwd_control
  import pwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        slotEn,
  input  logic        refLast,
  output pwdStrobes_t strb
);

  pwdState_t state;
  pwdState_t stateNext;

  always_comb begin
    strb.clearAll = clear;
    strb.countEn  = (state == PWD_RUN) && slotEn && !clear;
    strb.latch    = strb.countEn && refLast;
  end

  always_comb begin
    stateNext = state;
    if (clear)           stateNext = PWD_RUN;
    else if (strb.latch) stateNext = PWD_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PWD_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataIn,
  input  pwdStrobes_t  strb,
  output logic         refLast,
  output logic [N-1:0] result,
  output logic         resultValid
);

  localparam logic [N-1:0] TOP = '1;
  localparam logic [N-1:0] ONE = N'(1);

  logic         hit;
  logic         dataInc;
  logic [N-1:0] refCnt;
  logic [N-1:0] dataCnt;
  logic [N-1:0] dataFinal;

  pwd_edge_catch u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .clr     (strb.clearAll),
    .consume (strb.countEn),
    .hit     (hit)
  );

  assign dataInc = strb.countEn & hit;

  pwd_counter #(.W(N), .SATURATE(1'b0)) u_refCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strb.clearAll),
    .inc  (strb.countEn),
    .cnt  (refCnt)
  );

  pwd_counter #(.W(N), .SATURATE(1'b1)) u_dataCnt (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strb.clearAll),
    .inc  (dataInc),
    .cnt  (dataCnt)
  );

  assign refLast   = (refCnt == TOP);
  assign dataFinal = (dataInc && dataCnt != TOP) ? dataCnt + ONE : dataCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.latch;
      if (strb.latch) result <= dataFinal;
    end
  end

endmodule

// File: rtl/pulse_window_decoder.sv
module pulse_window_decoder
  import pwd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         slotEn,
  input  logic         dataIn,
  output logic [N-1:0] result,
  output logic         resultValid
);

  pwdStrobes_t strb;
  logic        refLast;

  pwd_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .slotEn  (slotEn),
    .refLast (refLast),
    .strb    (strb)
  );

  pwd_datapath #(.N(N)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .strb        (strb),
    .refLast     (refLast),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         clear,
  input logic         slotEn,
  input logic         dataIn,
  input logic [N-1:0] result,
  input logic         resultValid
);

  localparam int          SLOTS = 1 << N;
  localparam logic [N:0]  SLOTS_V = (N+1)'(SLOTS);

  logic       armed;
  logic       running;
  logic [N:0] tally;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      running <= 1'b0;
      tally   <= '0;
    end else begin
      armed <= 1'b1;
      if (clear) begin
        running <= 1'b1;
        tally   <= '0;
      end else if (running && slotEn) begin
        tally <= tally + 1'b1;
        if (tally == SLOTS_V - 1'b1) running <= 1'b0;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R4

  AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ($past(slotEn) && !$past(clear))); // R4

  AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (tally == SLOTS_V)); // R2

  AST_CLEAR_BLOCKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !resultValid); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !resultValid) |-> $stable(result)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !running && !$past(running)) |-> !resultValid); // R6

  wire unusedData = dataIn;

endmodule

bind pulse_window_decoder pwd_checker #(.N(N)) u_pwdChecker (
  .clk         (clk),
  .rstN        (rstN),
  .clear       (clear),
  .slotEn      (slotEn),
  .dataIn      (dataIn),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/pulse_window_decoder_bench.sv
module pulse_window_decoder_bench;

  localparam int N     = 3;
  localparam int SLOTS = 1 << N;
  localparam int TOPV  = SLOTS - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         clear = 1'b0;
  logic         slotEn = 1'b0;
  logic         dataIn = 1'b0;
  logic [N-1:0] result;
  logic         resultValid;

  int checks = 0;
  int errors = 0;
  int validSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pulse_window_decoder #(.N(N)) u_pulse_window_decoder (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (clear),
    .slotEn      (slotEn),
    .dataIn      (dataIn),
    .result      (result),
    .resultValid (resultValid)
  );

  always @(negedge clk) if (resultValid === 1'b1) validSeen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  // pulse (optional) one cycle before the slot strobe
  task automatic slotSep(input bit p);
    @(negedge clk) dataIn = p;
    @(negedge clk) begin dataIn = 1'b0; slotEn = 1'b1; end
    @(negedge clk) slotEn = 1'b0;
  endtask

  // pulse in the same cycle as the slot strobe
  task automatic slotSame(input bit p);
    @(negedge clk) begin dataIn = p; slotEn = 1'b1; end
    @(negedge clk) begin dataIn = 1'b0; slotEn = 1'b0; end
  endtask

  initial begin
    int v0;
    int r0;
    int pc;
    idle(3);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset valid", int'(resultValid), 0);
    @(negedge clk) rstN = 1'b1;
    idle(3);
    chk("R1 post-reset result", int'(result), 0);
    chk("R1 post-reset valid", validSeen, 0);

    // R4 R5: every slot pattern, pulses one cycle ahead of the strobe
    for (int pat = 0; pat < (1 << SLOTS); pat++) begin
      v0 = validSeen;
      pulseClear();
      for (int i = 0; i < SLOTS; i++) slotSep(pat[i]);
      idle(2);
      pc = $countones(pat);
      chk("R4 valid once", validSeen - v0, 1);
      if (pc == SLOTS) chk("R5 saturation", int'(result), TOPV);
      else             chk("R4 result", int'(result), pc);
    end

    // R3: pulse coinciding with the slot strobe
    for (int pat = 0; pat < (1 << SLOTS); pat += 37) begin
      v0 = validSeen;
      pulseClear();
      for (int i = 0; i < SLOTS; i++) slotSame(pat[i]);
      idle(2);
      pc = $countones(pat);
      chk("R3 same-cycle valid", validSeen - v0, 1);
      chk("R3 same-cycle count", int'(result), (pc > TOPV) ? TOPV : pc);
    end

    // R3: level held high across all slots counts once
    pulseClear();
    @(negedge clk) dataIn = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      @(negedge clk) slotEn = 1'b1;
      @(negedge clk) slotEn = 1'b0;
    end
    @(negedge clk) dataIn = 1'b0;
    idle(2);
    chk("R3 held level", int'(result), 1);

    // R6: idle after window
    r0 = int'(result);
    v0 = validSeen;
    for (int i = 0; i < SLOTS + 2; i++) slotSep(1'b1);
    idle(2);
    chk("R6 idle valid", validSeen - v0, 0);
    chk("R6 idle result", int'(result), r0);

    // R2: irregular gaps between slots
    v0 = validSeen;
    pulseClear();
    for (int i = 0; i < SLOTS; i++) begin
      idle(i % 3);
      slotSep(i < 6);
    end
    idle(2);
    chk("R2 gapped valid", validSeen - v0, 1);
    chk("R2 gapped result", int'(result), 6);

    // R7: clear mid-window restarts
    v0 = validSeen;
    pulseClear();
    for (int i = 0; i < 4; i++) slotSep(1'b1);
    pulseClear();
    for (int i = 0; i < SLOTS; i++) slotSep(i == 1 || i == 5);
    idle(2);
    chk("R7 restart valid", validSeen - v0, 1);
    chk("R7 restart result", int'(result), 2);

    // R7 R9: clear collides with the final slot
    pulseClear();
    for (int i = 0; i < SLOTS - 1; i++) slotSep(1'b1);
    r0 = int'(result);
    v0 = validSeen;
    @(negedge clk) begin slotEn = 1'b1; clear = 1'b1; end
    @(negedge clk) begin slotEn = 1'b0; clear = 1'b0; end
    idle(2);
    chk("R7 collision valid", validSeen - v0, 0);
    chk("R7 collision result", int'(result), r0);
    for (int i = 0; i < SLOTS - 1; i++) slotSep(i % 2 == 0);
    idle(2);
    chk("R9 colliding strobe not counted", validSeen - v0, 0);
    slotSep(1'b1);
    idle(2);
    chk("R9 window after collision valid", validSeen - v0, 1);
    chk("R9 window after collision result", int'(result), 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule